// File: doc/BRIEF.md
# Dual-Channel Modulo Timer with Linked-Pair PWM Output

This block is a counting timer whose period is set by a modulo value. It drives one PWM pin from a pair of compare channels. The counter advances by one each clock while it runs. It returns to zero after it reaches the modulo value, and that return is the overflow event. Each channel has a compare value and a small control field. At an overflow the pin goes to its pulse level. On a compare match the pin is forced to the opposite level. The pin therefore carries a pulse whose width is the compare value, in counts.

Channel 0 owns the pin. In unbuffered mode channel 0's compare value governs the pin, and a write to it takes effect at once. In buffered mode the two compare registers form a double buffer. Software writes the channel that is not in use, and the pin moves to that value only at the next overflow, so a period is never cut short or stretched.

Registers are loaded through a synchronous write port. The port has no back-pressure: a write presented with `wr_en` high is always taken in that cycle. Because the port carries configuration and not a data stream, it has no valid/ready pair.

Top module: `pwm_pair_timer`

## Requirements
- R1: While the stop bit (control register at address 0, bit 0, set to 1 at reset) is 1, `count` holds its value and no overflow or compare event is raised.
- R2: A write to address 0 with bit 1 set clears `count` to 0 at that clock edge. This bit is not stored and reads as a one-cycle command.
- R3: While running, `ovf_evt` is high in the cycle where `count` is at or above the modulo value (address 1, reset value all ones). In the next cycle `count` is 0; otherwise `count` increments by one.
- R4: With channel-0 mode bits (address 4, bits 4:3) set to 01, the pin follows channel 0's compare value (address 2). A write to the compare or modulo register takes effect in the current period.
- R5: Match action bits (bits 2:1 of a channel control word): 10 drives the pin low on a match, 11 drives it high, 01 toggles it, 00 does nothing. A match is the count reaching the compare value.
- R6: With the overflow bit (bit 0) set, an overflow returns the pin to the pulse level, which is the opposite of the match level; with action 01 or 00 it toggles the pin. With the overflow bit clear, an overflow leaves the pin alone.
- R7: Channel-0 mode bit 4 set links the pair. The pin then uses channel 0's control word, and channel 0's compare register (address 2) governs first.
- R8: Mode 11 behaves as buffered mode: bit 4 takes priority over bit 3.
- R9: In buffered mode, a write to the compare register of the channel not in use (address 2 or 3) makes that channel the one in use from the next overflow onward. Control alternates between the two channels with each such write.
- R10: In steady PWM, the pin is at the pulse level exactly while `count` is below the governing compare value. A value of 0 gives a constant pin at the match level, and a value above the modulo gives a constant pin at the pulse level, with no glitch at the overflow.
- R11: `cmp_evt[i]` is high while running in each cycle where `count` equals channel i's compare register.
- R12: With channel-0 mode 00 the pin holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 3 | Register address: 0 control, 1 modulo, 2/3 compare ch0/ch1, 4/5 control word ch0/ch1 |
| wr_data | input | W | Write data (control words use bits 4:0) |
| count | output | W | Present counter value |
| pwm_o | output | 1 | PWM pin |
| ovf_evt | output | 1 | Overflow event, one cycle |
| cmp_evt | output | 2 | Per-channel compare-match events |

## Verification
The assertions watch, on every cycle, that the count holds while stopped and clears after a reset command or an overflow. They also check that the pin stays constant in the 0% and 100% duty cases and while channel 0 is off, and that the buffered pair changes channel only at an overflow. Pulse widths under a range of periods and duties, the hand-over of control between the linked compare registers, the in-period effect of unbuffered writes, and the match-action and overflow-option variants can only be shown by the bench's scenarios. In those scenarios the pin is compared cycle by cycle with a model driven from the count.

// File: rtl/pwm_pair_pkg.sv
`timescale 1ns/1ps
package pwm_pair_pkg;
  localparam int AW = 3;
  localparam int NCH = 2;

  localparam logic [AW-1:0] ADDR_CTRL = 3'd0;
  localparam logic [AW-1:0] ADDR_MOD  = 3'd1;
  localparam logic [AW-1:0] ADDR_CMP0 = 3'd2;
  localparam logic [AW-1:0] ADDR_CW0  = 3'd4;

  localparam int CTRL_STOP_BIT = 0;
  localparam int CTRL_CLR_BIT  = 1;

  // channel mode field: bit 1 = linked/buffered, bit 0 = single/unbuffered
  typedef enum logic [1:0] {
    MATCH_NONE   = 2'b00,
    MATCH_TOGGLE = 2'b01,
    MATCH_LOW    = 2'b10,
    MATCH_HIGH   = 2'b11
  } match_act_e;

  typedef struct packed {
    logic [1:0] mode;
    match_act_e on_match;
    logic       tov;
  } ch_ctrl_t;

  localparam int CW_BITS = $bits(ch_ctrl_t);
endpackage

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop,
  input  logic         clr,
  input  logic [W-1:0] mod_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         run,
  output logic         wrap
);
  // at-or-above keeps a smaller modulo written mid-period from running to full scale
  assign run     = !stop && !clr;
  assign wrap    = cnt >= mod_val;
  assign cnt_nxt = wrap ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/pwm_buf_sel.sv
`timescale 1ns/1ps
module pwm_buf_sel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         linked,
  input  logic         adv_wrap,
  input  logic         wr_cmp,
  input  logic         wr_idx,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  output logic         act_sel,
  output logic [W-1:0] cmp_eff
);
  logic pend;
  logic swap;
  logic sel_now;

  assign swap    = linked && adv_wrap && pend;
  assign sel_now = swap ? ~act_sel : act_sel;
  // the comparison is made against the count after the edge, so a swap must be seen here
  assign cmp_eff = sel_now ? cmp1 : cmp0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= 1'b0;
      pend    <= 1'b0;
    end else if (!linked) begin
      act_sel <= 1'b0;
      pend    <= 1'b0;
    end else if (swap) begin
      act_sel <= ~act_sel;
      pend    <= 1'b0;
    end else if (wr_cmp && (wr_idx != act_sel)) begin
      pend    <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_out_stage.sv
`timescale 1ns/1ps
module pwm_out_stage
  import pwm_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         run,
  input  logic         wrap,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] cmp_eff,
  input  ch_ctrl_t     ctl,
  output logic         pin
);
  logic nxt;

  always_comb begin
    nxt = pin;
    if (en && run) begin
      if (wrap && ctl.tov) begin
        if (ctl.on_match[1]) nxt = ~ctl.on_match[0];
        else                 nxt = ~pin;
      end
      // a match on the new count overrides the overflow action
      if (cnt_nxt == cmp_eff) begin
        unique case (ctl.on_match)
          MATCH_LOW:    nxt = 1'b0;
          MATCH_HIGH:   nxt = 1'b1;
          MATCH_TOGGLE: nxt = ~nxt;
          default:      nxt = nxt;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= nxt;
  end
endmodule

// File: rtl/pwm_pair_timer.sv
`timescale 1ns/1ps
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [W-1:0]         wr_data,
  output logic [W-1:0]         count,
  output logic                 pwm_o,
  output logic                 ovf_evt,
  output logic [NCH-1:0]       cmp_evt
);
  logic              stop_q;
  logic [W-1:0]      mod_q;
  logic [W-1:0]      cmp_q [NCH];
  ch_ctrl_t          ctl_q [NCH];
  logic              clr_cmd;
  logic [W-1:0]      cnt_nxt;
  logic              run;
  logic              wrap;
  logic              linked;
  logic              ch0_on;
  logic              wr_cmp;
  logic              act_sel;
  logic [W-1:0]      cmp_eff;

  assign clr_cmd = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CTRL_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      mod_q  <= '1;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL) stop_q <= wr_data[CTRL_STOP_BIT];
      if (wr_addr == ADDR_MOD)  mod_q  <= wr_data;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] A_CMP = AW'(ADDR_CMP0 + i);
    localparam logic [AW-1:0] A_CW  = AW'(ADDR_CW0 + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[i] <= '0;
        ctl_q[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == A_CMP) cmp_q[i] <= wr_data;
        if (wr_addr == A_CW)  ctl_q[i] <= ch_ctrl_t'(wr_data[CW_BITS-1:0]);
      end
    end
    assign cmp_evt[i] = run && (count == cmp_q[i]);
  end

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .stop(stop_q), .clr(clr_cmd), .mod_val(mod_q),
    .cnt(count), .cnt_nxt(cnt_nxt), .run(run), .wrap(wrap)
  );

  assign ovf_evt = run && wrap;
  assign linked  = ctl_q[0].mode[1];
  assign ch0_on  = |ctl_q[0].mode;
  assign wr_cmp  = wr_en && (wr_addr[AW-1:1] == ADDR_CMP0[AW-1:1]);

  pwm_buf_sel #(.W(W)) u_sel (
    .clk(clk), .rst_n(rst_n), .linked(linked), .adv_wrap(ovf_evt),
    .wr_cmp(wr_cmp), .wr_idx(wr_addr[0]), .cmp0(cmp_q[0]), .cmp1(cmp_q[1]),
    .act_sel(act_sel), .cmp_eff(cmp_eff)
  );

  pwm_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .en(ch0_on), .run(run), .wrap(wrap),
    .cnt_nxt(cnt_nxt), .cmp_eff(cmp_eff), .ctl(ctl_q[0]), .pin(pwm_o)
  );
endmodule

// File: rtl/pwm_pair_timer_chk.sv
`timescale 1ns/1ps
module pwm_pair_timer_chk
  import pwm_pair_pkg::*;
#(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [W-1:0]  wr_data,
  input logic [W-1:0]  count,
  input logic          pwm_o,
  input logic          ovf_evt,
  input logic          stop_q,
  input logic          act_sel,
  input logic [W-1:0]  mod_q,
  input logic [W-1:0]  cmp0_q,
  input ch_ctrl_t      ctl0
);
  logic ctrl_wr;
  logic linked;
  logic single_low;
  assign ctrl_wr    = wr_en && (wr_addr == ADDR_CTRL);
  assign linked     = ctl0.mode[1];
  assign single_low = (ctl0.mode == 2'b01) && (ctl0.on_match == MATCH_LOW);

  p_stop_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !ctrl_wr) |=> (count == $past(count)));

  p_clear_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[CTRL_CLR_BIT]) |=> (count == '0));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (count == '0));

  p_ovf_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> !stop_q);

  p_zero_duty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_o && single_low && cmp0_q == '0 && !wr_en) |=> !pwm_o);

  p_full_duty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_o && single_low && cmp0_q > mod_q && !wr_en) |=> pwm_o);

  p_swap_at_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (linked && $past(linked) && act_sel != $past(act_sel)) |-> $past(ovf_evt));

  p_off_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0.mode == 2'b00 && !wr_en) |=> $stable(pwm_o));
endmodule

bind pwm_pair_timer pwm_pair_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .count(count), .pwm_o(pwm_o), .ovf_evt(ovf_evt), .stop_q(stop_q),
  .act_sel(act_sel), .mod_q(mod_q), .cmp0_q(cmp_q[0]), .ctl0(ctl_q[0])
);

// File: tb/pwm_pair_timer_tb.sv
`timescale 1ns/1ps
module pwm_pair_timer_tb;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic pwm_o, ovf_evt;
  logic [1:0] cmp_evt;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_pair_timer #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .pwm_o(pwm_o), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int cw(input int mode, input int act, input int tov);
    return (mode << 3) | (act << 1) | tov;
  endfunction

  task automatic halt(); wr(3'd0, 3); endtask
  task automatic go();   wr(3'd0, 0); endtask

  // pulse level is 1 for match-low, 0 for match-high
  task automatic check_periods(input int n, input int m, input int c, input bit hi_match,
                               input string tag);
    while (!ovf_evt) @(negedge clk);
    for (int k = 0; k < n * (m + 1); k++) begin
      @(negedge clk);
      chk(pwm_o == ((int'(count) < c) ? !hi_match : hi_match), tag, pwm_o,
          (int'(count) < c) ? !hi_match : hi_match);
    end
  endtask

  task automatic rest_of_period(input int c, input string tag);
    while (!ovf_evt) begin
      chk(pwm_o == (int'(count) < c), tag, pwm_o, int'(count) < c);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(count == 0, "R1 reset count", count, 0);
    chk(pwm_o == 0, "R12 reset pin", pwm_o, 0);
    chk(ovf_evt == 0 && cmp_evt == 0, "R1 reset events", {ovf_evt, cmp_evt}, 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(count == 0 && !ovf_evt, "R1 stopped at reset", count, 0);
    end
  endtask

  task automatic t_events();
    bit prev_ovf = 1'b0;
    halt(); wr(3'd1, 5); wr(3'd2, 2); wr(3'd3, 4); go();
    for (int k = 0; k < 18; k++) begin
      @(negedge clk);
      if (prev_ovf) chk(count == 0, "R3 wrap to zero", count, 0);
      chk(ovf_evt == (count == 5), "R3 overflow event", ovf_evt, count == 5);
      chk(cmp_evt[0] == (count == 2), "R11 ch0 match event", cmp_evt[0], count == 2);
      chk(cmp_evt[1] == (count == 4), "R11 ch1 match event", cmp_evt[1], count == 4);
      prev_ovf = ovf_evt;
    end
  endtask

  task automatic t_stop_clear();
    logic [W-1:0] held;
    halt(); wr(3'd1, 20); go();
    repeat (6) @(negedge clk);
    wr(3'd0, 1);
    held = count;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(count == held && !ovf_evt, "R1 hold while stopped", count, held);
    end
    go();
    repeat (3) @(negedge clk);
    wr(3'd0, 2);
    chk(count == 0, "R2 clear while running", count, 0);
    @(negedge clk);
    chk(count == 1, "R2 counts on after clear", count, 1);
  endtask

  task automatic t_sweep();
    int ms[8] = '{9, 9, 9, 15, 4, 20, 6, 6};
    int cs[8] = '{3, 0, 12, 15, 2, 7, 0, 7};
    bit hs[8] = '{0, 0, 0, 0, 1, 1, 1, 1};
    for (int i = 0; i < 8; i++) begin
      halt(); wr(3'd1, ms[i]); wr(3'd2, cs[i]); wr(3'd4, cw(1, hs[i] ? 3 : 2, 1)); go();
      if (cs[i] == 0 || cs[i] > ms[i]) check_periods(2, ms[i], cs[i], hs[i], "R10 constant duty");
      else check_periods(2, ms[i], cs[i], hs[i], "R4 R5 R6 duty");
    end
  endtask

  task automatic t_immediate();
    bit seen = 1'b0;
    halt(); wr(3'd1, 9); wr(3'd2, 2); wr(3'd4, cw(1, 2, 1)); go();
    check_periods(1, 9, 2, 1'b0, "R4 before write");
    wr(3'd2, 7);
    chk(count == 1, "R4 write point", count, 1);
    for (int k = 0; k < 19; k++) begin
      chk(pwm_o == (int'(count) < 7), "R4 compare write at once", pwm_o, int'(count) < 7);
      @(negedge clk);
    end
    while (count != 1) @(negedge clk);
    wr(3'd1, 4);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (count == 4) begin
        seen = 1'b1;
        chk(ovf_evt == 1, "R4 modulo write at once", ovf_evt, 1);
      end
    end
    chk(seen, "R4 new modulo reached", seen, 1);
  endtask

  task automatic t_actions();
    logic prev;
    halt(); wr(3'd1, 7); wr(3'd2, 3); wr(3'd4, cw(1, 1, 0)); go();
    prev = pwm_o;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (count == 3) chk(pwm_o != prev, "R5 toggle on match", pwm_o, !prev);
      else chk(pwm_o == prev, "R6 no overflow action", pwm_o, prev);
      prev = pwm_o;
    end
    halt(); wr(3'd4, cw(1, 2, 0)); go();
    while (count != 3) @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(pwm_o == 0, "R6 overflow bit clear keeps low", pwm_o, 0);
    end
  endtask

  task automatic t_buffered();
    halt(); wr(3'd4, 0); wr(3'd1, 9); wr(3'd2, 3); wr(3'd3, 6);
    wr(3'd4, cw(2, 2, 1)); go();
    check_periods(1, 9, 3, 1'b0, "R7 channel 0 first");
    wr(3'd3, 6);
    rest_of_period(3, "R9 period kept after write");
    check_periods(2, 9, 6, 1'b0, "R9 channel 1 after overflow");
    wr(3'd2, 2);
    rest_of_period(6, "R9 period kept after write");
    check_periods(1, 9, 2, 1'b0, "R9 back to channel 0");
  endtask

  task automatic t_priority();
    halt(); wr(3'd4, 0); wr(3'd1, 9); wr(3'd2, 4); wr(3'd3, 8);
    wr(3'd4, cw(3, 2, 1)); go();
    check_periods(1, 9, 4, 1'b0, "R8 mode 11 starts on channel 0");
    wr(3'd3, 8);
    rest_of_period(4, "R8 mode 11 keeps period");
    check_periods(1, 9, 8, 1'b0, "R8 mode 11 is buffered");
  endtask

  task automatic t_off();
    logic lvl;
    halt(); wr(3'd1, 9); wr(3'd2, 12); wr(3'd4, cw(1, 2, 1)); go();
    check_periods(1, 9, 12, 1'b0, "R10 full duty");
    halt(); wr(3'd4, 0); wr(3'd2, 3);
    lvl = pwm_o;
    go();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(pwm_o == lvl, "R12 pin holds with mode 00", pwm_o, lvl);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_stop_clear();
    t_sweep();
    t_immediate();
    t_actions();
    t_buffered();
    t_priority();
    t_off();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule